// File: doc/BRIEF.md
# Serial Converter Frame Readout Controller

This block is the host side of a three-wire link to a 14-bit sampling converter. It drives an active-low chip select and a shift clock, and it samples the converter's serial data line. Each frame opens with chip select falling, which starts a conversion. During the frame the shift clock clocks the conversion and also shifts out the result of the sample taken before it. The controller therefore returns each word one frame late, and it discards the word from the first frame after reset.

Every frame carries exactly 16 falling shift-clock edges. Chip select rises half a clock period after the last falling edge, so no sample is ever cut short. The serial stream opens with two zero bits and then carries 14 data bits, most significant first. The controller checks the two zero positions and flags the frame when either one reads as one. There are two run-time modes. In the first, the shift clock is held high for a programmable acquisition time between frames. In the second, the clock keeps toggling and acquisition is four clock periods long. Frames start from a one-shot request or repeat back to back while a run enable is held.

Top module: `adc_readout_ctrl`

## Requirements
- R1: During and after reset, until the first request, csN and sclk are high, and dataValid, frameErr and dataOut are all zero.
- R2: Each frame holds csN low for exactly 32·D system cycles, where D = divVal (0 counts as 1). In that time sclk shows exactly 16 falling edges and each sclk level lasts D cycles. csN changes only while sclk is high.
- R3: When modeCont = 0 and runEn is held, csN stays high for exactly A cycles between frames, where A = acqLen (0 counts as 1). sclk stays high throughout that time.
- R4: When modeCont = 1 and runEn is held, csN stays high for exactly 8·D cycles (four clock periods) between frames. sclk toggles every D cycles with no gap.
- R5: sdi is sampled in the last system cycle of each high sclk level inside a frame, which gives 16 bits. Bits 15 and 14 (the first two sampled) are the leading positions. Bits 13..0 are the data word, received most significant bit first.
- R6: dataValid is a one-cycle pulse in the same cycle that csN returns high, and dataOut then holds the 14 data bits of that frame.
- R7: The first frame after reset produces no dataValid pulse.
- R8: frameErr is high together with dataValid when either leading position sampled as 1. frameErr is never high without dataValid.
- R9: A start pulse while idle runs exactly one frame. runEn runs frames back to back. Once runEn is low and the current frame has ended, csN and sclk stay high and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-shot frame request, taken while idle |
| runEn | input | 1 | Keep running frames back to back while high |
| modeCont | input | 1 | 0: clock held high during acquisition; 1: continuous clock |
| divVal | input | 4 | Length of one sclk level in system cycles (0 counts as 1) |
| acqLen | input | 6 | Acquisition length in system cycles when modeCont = 0 (0 counts as 1) |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Shift clock |
| dataOut | output | 14 | Last received data word |
| dataValid | output | 1 | One-cycle strobe marking a new word |
| frameErr | output | 1 | Leading-zero violation in the frame just reported |

## Verification
The table of frames mixes both modes with divider values 0 to 4 and acquisition lengths that include 0. It uses all-ones, all-zeros, alternating and single-bit words, so a bit-order slip, an off-by-one capture point or a lost bit gives a different word. The leading positions are corrupted one at a time (upper only, lower only, both), which separates a check that reads only one position from a correct one. Back-to-back runs in each mode measure how long chip select stays high and how long each clock level lasts, which tells the held-high acquisition apart from the fixed four-period continuous one. A first frame after reset and an idle stretch after run enable drops cover the latency and the stop behaviour.

// File: rtl/adc_readout_pkg.sv
package adc_readout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic sampleBit;  // capture sdi at this edge
    logic frameEnd;   // last cycle of the frame
  } dpCtl_t;

endpackage

// File: rtl/adc_readout_seq.sv
module adc_readout_seq
  import adc_readout_pkg::*;
#(
  parameter int DATA_W           = 14,
  parameter int LEAD_W           = 2,
  parameter int DIV_W            = 4,
  parameter int ACQ_W            = 6,
  parameter int CONT_ACQ_PERIODS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             runEn,
  input  logic             modeCont,
  input  logic [DIV_W-1:0] divVal,
  input  logic [ACQ_W-1:0] acqLen,
  output logic             csN,
  output logic             sclk,
  output dpCtl_t           ctl
);

  localparam int FRAME_BITS   = DATA_W + LEAD_W;
  localparam int FRAME_HALVES = 2 * FRAME_BITS;
  localparam int ACQ_HALVES   = 2 * CONT_ACQ_PERIODS;
  localparam int MAX_HALVES   = (FRAME_HALVES > ACQ_HALVES) ? FRAME_HALVES : ACQ_HALVES;
  localparam int HALF_W       = $clog2(MAX_HALVES);
  localparam int CNT_W        = (DIV_W > ACQ_W) ? DIV_W : ACQ_W;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phaseLen;
  logic [HALF_W-1:0] halfCnt;
  logic             modeR;
  logic [DIV_W-1:0] divR;
  logic [ACQ_W-1:0] acqR;
  logic             phaseEnd;
  logic             lastHalf;
  logic             acqDone;
  logic             cfgLoad;

  // length of the current phase in system cycles
  always_comb begin
    if (state == ST_ACQ && !modeR) phaseLen = CNT_W'(acqR);
    else                           phaseLen = CNT_W'(divR);
  end

  assign phaseEnd = (cnt == phaseLen - CNT_W'(1));
  assign lastHalf = (halfCnt == HALF_W'(FRAME_HALVES - 1));
  assign acqDone  = !modeR || (halfCnt == HALF_W'(ACQ_HALVES - 1));

  assign ctl.sampleBit = (state == ST_CONV) && sclk && phaseEnd;
  assign ctl.frameEnd  = (state == ST_CONV) && phaseEnd && lastHalf;

  // configuration is captured whenever an acquisition begins
  assign cfgLoad = ((state == ST_IDLE) && (start || runEn)) ||
                   (ctl.frameEnd && runEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR <= 1'b0;
      divR  <= DIV_W'(1);
      acqR  <= ACQ_W'(1);
    end else if (cfgLoad) begin
      modeR <= modeCont;
      divR  <= (divVal == '0) ? DIV_W'(1) : divVal;
      acqR  <= (acqLen == '0) ? ACQ_W'(1) : acqLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      halfCnt <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt     <= '0;
          halfCnt <= '0;
          csN     <= 1'b1;
          sclk    <= 1'b1;
          if (start || runEn) state <= ST_ACQ;
        end
        ST_ACQ: begin
          if (!phaseEnd) begin
            cnt <= cnt + CNT_W'(1);
          end else begin
            cnt <= '0;
            if (acqDone) begin
              state   <= ST_CONV;
              csN     <= 1'b0;
              sclk    <= 1'b1;
              halfCnt <= '0;
            end else begin
              halfCnt <= halfCnt + HALF_W'(1);
              sclk    <= ~sclk;
            end
          end
        end
        ST_CONV: begin
          if (!phaseEnd) begin
            cnt <= cnt + CNT_W'(1);
          end else begin
            cnt <= '0;
            if (lastHalf) begin
              csN     <= 1'b1;
              sclk    <= 1'b1;
              halfCnt <= '0;
              state   <= runEn ? ST_ACQ : ST_IDLE;
            end else begin
              halfCnt <= halfCnt + HALF_W'(1);
              sclk    <= ~sclk;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          csN   <= 1'b1;
          sclk  <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_readout_dp.sv
module adc_readout_dp
  import adc_readout_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int LEAD_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  dpCtl_t            ctl,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              frameErr
);

  localparam int FRAME_BITS = DATA_W + LEAD_W;

  logic [FRAME_BITS-1:0] shReg;
  logic                  primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      primed    <= 1'b0;
      dataOut   <= '0;
      dataValid <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      frameErr  <= 1'b0;
      if (ctl.sampleBit) shReg <= {shReg[FRAME_BITS-2:0], sdi};
      if (ctl.frameEnd) begin
        primed <= 1'b1;
        // the first frame carries a word from before reset
        if (primed) begin
          dataValid <= 1'b1;
          dataOut   <= shReg[DATA_W-1:0];
          frameErr  <= |shReg[FRAME_BITS-1 -: LEAD_W];
        end
      end
    end
  end

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_readout_pkg::*;
#(
  parameter int DATA_W           = 14,
  parameter int LEAD_W           = 2,
  parameter int DIV_W            = 4,
  parameter int ACQ_W            = 6,
  parameter int CONT_ACQ_PERIODS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              runEn,
  input  logic              modeCont,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [ACQ_W-1:0]  acqLen,
  input  logic              sdi,
  output logic              csN,
  output logic              sclk,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              frameErr
);

  dpCtl_t ctl;

  adc_readout_seq #(
    .DATA_W(DATA_W), .LEAD_W(LEAD_W), .DIV_W(DIV_W),
    .ACQ_W(ACQ_W), .CONT_ACQ_PERIODS(CONT_ACQ_PERIODS)
  ) u_seq (
    .clk(clk), .rstN(rstN), .start(start), .runEn(runEn),
    .modeCont(modeCont), .divVal(divVal), .acqLen(acqLen),
    .csN(csN), .sclk(sclk), .ctl(ctl)
  );

  adc_readout_dp #(
    .DATA_W(DATA_W), .LEAD_W(LEAD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdi(sdi), .ctl(ctl),
    .dataOut(dataOut), .dataValid(dataValid), .frameErr(frameErr)
  );

endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk #(
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic dataValid,
  input logic frameErr
);

  localparam int FC_W = $clog2(FRAME_BITS + 1) + 1;

  logic [FC_W-1:0] fallCnt;
  logic            prevSclk;
  logic            prevCsN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallCnt  <= '0;
      prevSclk <= 1'b1;
      prevCsN  <= 1'b1;
    end else begin
      prevSclk <= sclk;
      prevCsN  <= csN;
      if (!csN && prevSclk && !sclk) fallCnt <= fallCnt + FC_W'(1);
      else if (csN && prevCsN)       fallCnt <= '0;
    end
  end

  assert_cs_edge_sclk_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csN) || $fell(csN)) |-> sclk);

  assert_frame_falls_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (fallCnt == FC_W'(FRAME_BITS)));

  assert_valid_at_cs_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $rose(csN));

  assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> dataValid);

endmodule

bind adc_readout_ctrl adc_readout_chk #(.FRAME_BITS(DATA_W + LEAD_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
  .dataValid(dataValid), .frameErr(frameErr)
);

// File: tb/adc_readout_ctrl_bench.sv
`timescale 1ns/1ps
module adc_readout_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        runEn = 1'b0;
  logic        modeCont = 1'b0;
  logic [3:0]  divVal = 4'd1;
  logic [5:0]  acqLen = 6'd1;
  logic        sdi = 1'b0;
  logic        csN;
  logic        sclk;
  logic [13:0] dataOut;
  logic        dataValid;
  logic        frameErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_readout_ctrl u_adc_readout_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .runEn(runEn),
    .modeCont(modeCont), .divVal(divVal), .acqLen(acqLen), .sdi(sdi),
    .csN(csN), .sclk(sclk), .dataOut(dataOut), .dataValid(dataValid),
    .frameErr(frameErr)
  );

  // converter model: word of the previous sample, two leading positions first
  logic [15:0] mShift = '0;
  logic [13:0] mPrev = '0;
  logic [13:0] mNext = '0;
  logic [1:0]  mLead = '0;

  always @(negedge csN) begin
    mShift = {mLead, mPrev};
    mPrev  = mNext;
    sdi    = mShift[15];
  end
  always @(negedge sclk) begin
    if (!csN) begin
      mShift = mShift << 1;
      sdi    = mShift[15];
    end
  end
  always @(posedge csN) sdi = 1'b0;

  // port monitors, sampled at the active edge before outputs update
  int lowRun = 0, lastLow = 0, highRun = 0, lastHigh = 0;
  int fallRun = 0, lvlRun = 0, maxRun = 0, csFalls = 0;
  bit prevS = 1'b1, prevC = 1'b1, sclkLowInAcq = 1'b0;

  always @(posedge clk) begin
    if (!csN) begin
      lowRun = lowRun + 1; lastLow = lowRun; highRun = 0;
      if (prevS && !sclk) begin fallRun = fallRun + 1; end
    end else begin
      highRun = highRun + 1; lastHigh = highRun; lowRun = 0;
      if (prevC) fallRun = 0;
      if (!sclk) sclkLowInAcq = 1'b1;
    end
    if (prevC && !csN) csFalls = csFalls + 1;
    if (sclk == prevS) lvlRun = lvlRun + 1; else lvlRun = 1;
    if (lvlRun > maxRun) maxRun = lvlRun;
    prevS = sclk;
    prevC = csN;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitFrame();
    @(posedge csN);
    @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // {modeCont, divVal[3:0], acqLen[5:0], lead[1:0], sample[13:0]}
  localparam int NVEC = 8;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 4'd1, 6'd1, 2'b00, 14'h2ABC},
    {1'b0, 4'd2, 6'd3, 2'b00, 14'h3FFF},
    {1'b0, 4'd1, 6'd0, 2'b10, 14'h0000},
    {1'b1, 4'd1, 6'd1, 2'b00, 14'h1555},
    {1'b1, 4'd3, 6'd5, 2'b01, 14'h2AAA},
    {1'b0, 4'd0, 6'd2, 2'b00, 14'h0001},
    {1'b1, 4'd2, 6'd1, 2'b11, 14'h2000},
    {1'b0, 4'd4, 6'd7, 2'b00, 14'h1234}
  };

  initial begin
    logic [13:0] expWord;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "csN", int'(csN), 1);
    chk("R1", "sclk", int'(sclk), 1);
    chk("R1", "dataValid", int'(dataValid), 0);
    chk("R1", "frameErr", int'(frameErr), 0);
    chk("R1", "dataOut", int'(dataOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "csN idle after reset", int'(csN), 1);

    // R7: first frame after reset is dropped
    mNext = 14'h0F0F; mLead = 2'b00;
    pulseStart();
    waitFrame();
    chk("R7", "dataValid on first frame", int'(dataValid), 0);
    expWord = 14'h0F0F;

    // table of single frames (R2, R5, R6, R8, R9)
    for (int i = 0; i < NVEC; i++) begin
      int d;
      modeCont = VEC[i][26];
      divVal   = VEC[i][25:22];
      acqLen   = VEC[i][21:16];
      mLead    = VEC[i][15:14];
      mNext    = VEC[i][13:0];
      d = (VEC[i][25:22] == 4'd0) ? 1 : int'(VEC[i][25:22]);
      pulseStart();
      waitFrame();
      chk("R6", "dataValid", int'(dataValid), 1);
      chk("R5", "dataOut", int'(dataOut), int'(expWord));
      chk("R8", "frameErr", int'(frameErr), int'(VEC[i][15:14] != 2'b00));
      chk("R2", "csN low cycles", lastLow, 32 * d);
      chk("R2", "sclk falls", fallRun, 16);
      @(negedge clk);
      chk("R6", "dataValid pulse width", int'(dataValid), 0);
      chk("R9", "single frame then idle csN", int'(csN), 1);
      expWord = VEC[i][13:0];
    end

    // R3: held-high acquisition while running
    modeCont = 1'b0; divVal = 4'd2; acqLen = 6'd9; mLead = 2'b00;
    @(negedge clk); runEn = 1'b1;
    waitFrame();
    sclkLowInAcq = 1'b0;
    @(negedge csN); @(negedge clk);
    chk("R3", "acquisition cycles", lastHigh, 9);
    chk("R3", "sclk low during acquisition", int'(sclkLowInAcq), 0);
    chk("R2", "sclk level length D=2", maxRun >= 2 ? 2 : maxRun, 2);
    runEn = 1'b0;
    waitFrame();
    // R9: stays idle after runEn drops
    csFalls = 0;
    repeat (60) @(negedge clk);
    chk("R9", "frames after stop", csFalls, 0);
    chk("R9", "csN idle", int'(csN), 1);
    chk("R9", "sclk idle", int'(sclk), 1);

    // R4: continuous clock
    modeCont = 1'b1; divVal = 4'd2;
    @(negedge clk); runEn = 1'b1;
    @(negedge csN); @(negedge clk);
    maxRun = 0; sclkLowInAcq = 1'b0;
    @(negedge csN); @(negedge clk);
    chk("R4", "acquisition cycles", lastHigh, 16);
    @(negedge csN); @(negedge clk);
    chk("R4", "max sclk level run", maxRun, 2);
    chk("R4", "sclk toggles during acquisition", int'(sclkLowInAcq), 1);
    chk("R2", "csN low cycles running", lastLow < 64 ? 64 : lastLow, 64);
    runEn = 1'b0;
    waitFrame();
    chk("R2", "csN low cycles continuous", lastLow, 64);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule